// File: doc/BRIEF.md
# Line-Based Substrate Shutter Pulse Generator

This block drives the substrate shutter line of a CCD sensor, which clears accumulated charge and so sets the exposure time. In each field the block emits at most one main pulse per line. The pulses occupy a run of consecutive lines that begins a set distance after the field's sense-gate line. The length of that run sets the exposure. Where the main pulse sits within a line is given by rising and falling pixel positions. An optional extra pulse on the last pulsed line gives finer exposure control.

The timing source supplies a pixel position within the line, a one-cycle line strobe and a one-cycle field strobe. After either strobe, the cycles that follow carry pixel positions 0, 1, 2 and so on of the new line. The line that opens with the field strobe is line 0. The polarity, toggle, count and offset settings are copied into shadow registers only at the line strobe that ends the sense-gate line. This lets software write them at any time without breaking a field in progress. The extra-pulse setting is read live. All pins are plain level or strobe controls. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `sht_pulse_gen`

## Requirements
- R1: While reset is asserted, and afterwards until the first shadow load, `shutter` is 0. The shadow registers reset to polarity 0, count 0, offset 0 and toggles 0, so no pulses appear before the first load.
- R2: With offset 0, the pulsed lines are sg_line+1 through sg_line+count (line 0 is the line opened by the field strobe). No pulse appears on or before the sense-gate line.
- R3: An offset value n of 2 or more makes the first pulsed line sg_line+n.
- R4: An offset value of 1 behaves exactly like 0.
- R5: On a pulsed line, `shutter` is active in the cycle after each cycle whose pixel position p satisfies rise <= p < fall. The output is otherwise inactive, and a line with rise >= fall carries no main pulse.
- R6: The active level is high when the polarity shadow bit is 0 and low when it is 1. The inactive level is the inverse.
- R7: `cfg_hp` holds {fall[2*PW-1:PW], rise[PW-1:0]}. On the last pulsed line it adds a second active window for positions rise <= p < fall. The all-ones value disables this window.
- R8: Polarity, toggles, count and offset take effect only at the line strobe that ends line sg_line. Writes made later in the field have no effect until the next field's load.
- R9: The field strobe returns the line count to 0. Pulses therefore stop at the field boundary even when the programmed count runs past the end of the field.
- R10: A count of 0 produces no pulses in the field, and the extra pulse is not produced either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | One-cycle strobe opening a field (line 0) |
| line_start | input | 1 | One-cycle strobe opening the next line |
| pix_pos | input | PW | Pixel position within the current line |
| sg_line | input | LW | Sense-gate active line number of this field |
| cfg_pol | input | 1 | Polarity: 1 selects an active-low pulse |
| cfg_rise | input | PW | Main pulse start position |
| cfg_fall | input | PW | Main pulse end position (exclusive) |
| cfg_count | input | CW | Number of pulsed lines per field |
| cfg_start_off | input | LW | Start-line offset (0 or 1: next line; n: n lines after) |
| cfg_hp | input | 2*PW | Extra pulse {fall, rise} on the last pulsed line, all ones disables it |
| shutter | output | 1 | Substrate shutter output, registered |

## Verification
The bench builds the block with its default parameters: 12-bit pixel positions and line numbers, and an 8-bit count. With these widths the 24-bit all-ones value that disables the extra pulse is reached exactly. Pixel value 0xFFF, driven during strobe cycles, sits safely outside every window. The 8-bit count can exceed the lines in a short test field, which brings the cut-off at the field boundary within reach. Lines are 16 pixels long, so each field is checked position by position against a model in the bench within a few hundred cycles.

// File: rtl/sht_pkg.sv
package sht_pkg;
  // Classification of the current line for pulse generation
  typedef enum logic [1:0] {
    LN_IDLE  = 2'd0,
    LN_PULSE = 2'd1,
    LN_LAST  = 2'd2
  } line_kind_e;

  localparam int unsigned SHT_PW_DEF = 12;
  localparam int unsigned SHT_LW_DEF = 12;
  localparam int unsigned SHT_CW_DEF = 8;
endpackage

// File: rtl/sht_line_track.sv
module sht_line_track #(
  parameter int unsigned LW = 12,
  parameter int unsigned PW = 12,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  logic          line_start,
  input  logic [LW-1:0] sg_line,
  input  logic          cfg_pol,
  input  logic [PW-1:0] cfg_rise,
  input  logic [PW-1:0] cfg_fall,
  input  logic [CW-1:0] cfg_count,
  input  logic [LW-1:0] cfg_start_off,
  output logic [LW-1:0] line_idx,
  output logic          sh_pol,
  output logic [PW-1:0] sh_rise,
  output logic [PW-1:0] sh_fall,
  output logic [CW-1:0] sh_cnt,
  output logic [LW-1:0] sh_off
);
  logic load_sh;
  // Shadow copy happens as the sense-gate line closes
  assign load_sh = line_start && !field_start && (line_idx == sg_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_idx <= '0;
    end else if (field_start) begin
      line_idx <= '0;
    end else if (line_start && (line_idx != {LW{1'b1}})) begin
      line_idx <= line_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pol  <= 1'b0;
      sh_rise <= '0;
      sh_fall <= '0;
      sh_cnt  <= '0;
      sh_off  <= '0;
    end else if (load_sh) begin
      sh_pol  <= cfg_pol;
      sh_rise <= cfg_rise;
      sh_fall <= cfg_fall;
      sh_cnt  <= cfg_count;
      sh_off  <= cfg_start_off;
    end
  end

  // R9: a field strobe always restarts the line count
  p_clear_on_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (line_idx == '0));

  // R8: shadow settings hold except at the sense-gate line boundary
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_start && (line_idx == sg_line)) |=>
      $stable({sh_pol, sh_rise, sh_fall, sh_cnt, sh_off}));
endmodule

// File: rtl/sht_line_class.sv
module sht_line_class
  import sht_pkg::*;
#(
  parameter int unsigned LW = 12,
  parameter int unsigned CW = 8
) (
  input  logic [LW-1:0] line_idx,
  input  logic [LW-1:0] sg_line,
  input  logic [CW-1:0] sh_cnt,
  input  logic [LW-1:0] sh_off,
  output line_kind_e    kind
);
  localparam int unsigned EW = ((LW > CW) ? LW : CW) + 2;

  logic [EW-1:0] step, first_ln, end_ln, cur_ln;

  always_comb begin
    // Offsets 0 and 1 both mean the line right after the sense-gate line
    step     = (sh_off <= LW'(1)) ? EW'(1) : EW'(sh_off);
    first_ln = EW'(sg_line) + step;
    end_ln   = first_ln + EW'(sh_cnt);
    cur_ln   = EW'(line_idx);
    kind     = LN_IDLE;
    if ((cur_ln >= first_ln) && (cur_ln < end_ln)) begin
      kind = ((cur_ln + EW'(1)) == end_ln) ? LN_LAST : LN_PULSE;
    end
  end
endmodule

// File: rtl/sht_window.sv
module sht_window #(
  parameter int unsigned PW = 12
) (
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] lo,
  input  logic [PW-1:0] hi,
  input  logic          en,
  output logic          hit
);
  assign hit = en && (pos >= lo) && (pos < hi);
endmodule

// File: rtl/sht_pulse_gen.sv
module sht_pulse_gen
  import sht_pkg::*;
#(
  parameter int unsigned PW = SHT_PW_DEF,
  parameter int unsigned LW = SHT_LW_DEF,
  parameter int unsigned CW = SHT_CW_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            field_start,
  input  logic            line_start,
  input  logic [PW-1:0]   pix_pos,
  input  logic [LW-1:0]   sg_line,
  input  logic            cfg_pol,
  input  logic [PW-1:0]   cfg_rise,
  input  logic [PW-1:0]   cfg_fall,
  input  logic [CW-1:0]   cfg_count,
  input  logic [LW-1:0]   cfg_start_off,
  input  logic [2*PW-1:0] cfg_hp,
  output logic            shutter
);
  localparam int unsigned HW   = 2 * PW;
  localparam int unsigned NWIN = 2;

  logic [LW-1:0] line_idx;
  logic          sh_pol;
  logic [PW-1:0] sh_rise, sh_fall;
  logic [CW-1:0] sh_cnt;
  logic [LW-1:0] sh_off;
  line_kind_e    kind;
  logic          hp_enabled;
  logic          shutter_q;

  logic [PW-1:0]   win_lo [NWIN];
  logic [PW-1:0]   win_hi [NWIN];
  logic [NWIN-1:0] win_en;
  logic [NWIN-1:0] win_hit;

  sht_line_track #(.LW(LW), .PW(PW), .CW(CW)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .field_start   (field_start),
    .line_start    (line_start),
    .sg_line       (sg_line),
    .cfg_pol       (cfg_pol),
    .cfg_rise      (cfg_rise),
    .cfg_fall      (cfg_fall),
    .cfg_count     (cfg_count),
    .cfg_start_off (cfg_start_off),
    .line_idx      (line_idx),
    .sh_pol        (sh_pol),
    .sh_rise       (sh_rise),
    .sh_fall       (sh_fall),
    .sh_cnt        (sh_cnt),
    .sh_off        (sh_off)
  );

  sht_line_class #(.LW(LW), .CW(CW)) u_class (
    .line_idx (line_idx),
    .sg_line  (sg_line),
    .sh_cnt   (sh_cnt),
    .sh_off   (sh_off),
    .kind     (kind)
  );

  assign hp_enabled = (cfg_hp != {HW{1'b1}});

  // Window 0: main pulse on every pulsed line; window 1: extra pulse on the last
  always_comb begin
    win_lo[0] = sh_rise;
    win_hi[0] = sh_fall;
    win_en[0] = (kind != LN_IDLE);
    win_lo[1] = cfg_hp[PW-1:0];
    win_hi[1] = cfg_hp[HW-1:PW];
    win_en[1] = (kind == LN_LAST) && hp_enabled;
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    sht_window #(.PW(PW)) u_win (
      .pos (pix_pos),
      .lo  (win_lo[g]),
      .hi  (win_hi[g]),
      .en  (win_en[g]),
      .hit (win_hit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shutter_q <= 1'b0;
    else        shutter_q <= sh_pol ^ (|win_hit);
  end

  assign shutter = shutter_q;

  // R2: no line on or before the sense-gate line is ever classed as pulsed
  p_after_sg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != LN_IDLE) |-> (line_idx > sg_line));

  // R7: the all-ones setting suppresses the extra window
  p_hp_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hp == {HW{1'b1}}) |-> !win_hit[1]);

  // R10: a zero count leaves the output at its inactive level
  p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_cnt == '0) |=> (shutter == $past(sh_pol)));
endmodule

// File: tb/sim_sht_pulse_gen.sv
module sim_sht_pulse_gen;
  localparam int CLK_P    = 10;
  localparam int PW       = 12;
  localparam int LW       = 12;
  localparam int CW       = 8;
  localparam int LINE_PIX = 16;
  localparam int NV       = 10;

  typedef struct packed {
    logic [11:0] sg;
    logic        pol;
    logic [11:0] rise;
    logic [11:0] fall;
    logic [7:0]  cnt;
    logic [11:0] off;
    logic [23:0] hp;
    logic [7:0]  nl;
    logic [7:0]  exp_act;
  } vec_t;

  // sg, pol, rise, fall, count, offset, hp, lines, expected active lines
  localparam vec_t VECS [NV] = '{
    '{12'd2, 1'b0, 12'd3, 12'd7,  8'd3,  12'd0, 24'hFFFFFF, 8'd10, 8'd3},
    '{12'd1, 1'b0, 12'd0, 12'd16, 8'd2,  12'd2, 24'hFFFFFF, 8'd8,  8'd2},
    '{12'd1, 1'b0, 12'd5, 12'd6,  8'd4,  12'd1, 24'hFFFFFF, 8'd10, 8'd4},
    '{12'd0, 1'b1, 12'd2, 12'd10, 8'd2,  12'd0, 24'hFFFFFF, 8'd6,  8'd2},
    '{12'd2, 1'b0, 12'd1, 12'd3,  8'd3,  12'd0, 24'h00C009, 8'd10, 8'd3},
    '{12'd1, 1'b0, 12'd2, 12'd8,  8'd0,  12'd0, 24'h00C009, 8'd8,  8'd0},
    '{12'd3, 1'b0, 12'd4, 12'd9,  8'd20, 12'd4, 24'hFFFFFF, 8'd10, 8'd3},
    '{12'd1, 1'b0, 12'd9, 12'd9,  8'd2,  12'd0, 24'hFFFFFF, 8'd6,  8'd0},
    '{12'd0, 1'b0, 12'd2, 12'd4,  8'd1,  12'd3, 24'h00F00E, 8'd8,  8'd1},
    '{12'd2, 1'b1, 12'd6, 12'd8,  8'd2,  12'd0, 24'hFFFFFF, 8'd8,  8'd2}
  };
  // Requirement each vector mainly exercises: R2 R3 R4 R6 R7 R10 R9 R5 R3 R6
  localparam string TAGS [NV] = '{"R2", "R3", "R4", "R6", "R7",
                                  "R10", "R9", "R5", "R3/R7", "R6"};

  logic            clk = 1'b0;
  logic            rst_n;
  logic            field_start, line_start;
  logic [PW-1:0]   pix_pos;
  logic [LW-1:0]   sg_line;
  logic            cfg_pol;
  logic [PW-1:0]   cfg_rise, cfg_fall;
  logic [CW-1:0]   cfg_count;
  logic [LW-1:0]   cfg_start_off;
  logic [2*PW-1:0] cfg_hp;
  logic            shutter;

  int n_chk = 0;
  int n_err = 0;

  // Bench-side shadow model
  logic        m_pol;
  int          m_rise, m_fall, m_cnt, m_off;
  logic [PW-1:0] alt_rise, alt_fall;

  sht_pulse_gen #(.PW(PW), .LW(LW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_start(line_start),
    .pix_pos(pix_pos), .sg_line(sg_line), .cfg_pol(cfg_pol), .cfg_rise(cfg_rise),
    .cfg_fall(cfg_fall), .cfg_count(cfg_count), .cfg_start_off(cfg_start_off),
    .cfg_hp(cfg_hp), .shutter(shutter)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int ln, input int p);
    int first, endl;
    bit inr, last, act;
    first = int'(sg_line) + ((m_off <= 1) ? 1 : m_off);
    endl  = first + m_cnt;
    inr   = (ln >= first) && (ln < endl);
    last  = inr && (ln + 1 == endl);
    act   = inr && (p >= m_rise) && (p < m_fall);
    if (last && (cfg_hp != 24'hFFFFFF) &&
        (p >= int'(cfg_hp[11:0])) && (p < int'(cfg_hp[23:12])))
      act = 1'b1;
    return m_pol ^ act;
  endfunction

  task automatic model_reset();
    m_pol = 1'b0; m_rise = 0; m_fall = 0; m_cnt = 0; m_off = 0;
  endtask

  task automatic model_load();
    m_pol = cfg_pol; m_rise = int'(cfg_rise); m_fall = int'(cfg_fall);
    m_cnt = int'(cfg_count); m_off = int'(cfg_start_off);
  endtask

  // One field; per-line mask check; returns count of lines with any active pixel
  task automatic run_field(input int nlines, input int chg_line,
                           input string tag, output int act_lines);
    logic [LINE_PIX-1:0] obs, expm, idle;
    act_lines = 0;
    field_start = 1'b1; pix_pos = '1;
    cyc();
    field_start = 1'b0;
    for (int ln = 0; ln < nlines; ln++) begin
      if (ln > 0) begin
        line_start = 1'b1; pix_pos = '1;
        if (ln - 1 == int'(sg_line)) model_load();
        cyc();
        line_start = 1'b0;
      end
      if (ln == chg_line) begin
        cfg_rise = alt_rise; cfg_fall = alt_fall;
      end
      for (int p = 0; p < LINE_PIX; p++) begin
        pix_pos = PW'(p);
        expm[p] = exp_bit(ln, p);
        cyc();
        obs[p] = shutter;
      end
      idle = {LINE_PIX{m_pol}};
      if (obs != idle) act_lines++;
      chk(obs == expm, $sformatf("%s line %0d", tag, ln), 32'(obs), 32'(expm));
    end
  endtask

  task automatic load_vec(input vec_t v);
    sg_line = v.sg; cfg_pol = v.pol; cfg_rise = v.rise; cfg_fall = v.fall;
    cfg_count = v.cnt; cfg_start_off = v.off; cfg_hp = v.hp;
  endtask

  initial begin
    int act;
    rst_n = 1'b0; field_start = 1'b0; line_start = 1'b0; pix_pos = '1;
    sg_line = '0; cfg_pol = 1'b1; cfg_rise = '0; cfg_fall = '0;
    cfg_count = '0; cfg_start_off = '0; cfg_hp = '1;
    alt_rise = '0; alt_fall = '0;
    model_reset();
    cyc();
    chk(shutter == 1'b0, "R1 in reset", 32'(shutter), 32'd0);
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    chk(shutter == 1'b0, "R1 after reset", 32'(shutter), 32'd0);

    // R1: no load happens (sense-gate line beyond field), defaults give no pulses
    sg_line = 12'd20; cfg_pol = 1'b0; cfg_rise = 12'd1; cfg_fall = 12'd9;
    cfg_count = 8'd5; cfg_start_off = '0; cfg_hp = '1;
    run_field(6, -1, "R1", act);
    chk(act == 0, "R1 active lines before load", 32'(act), 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      load_vec(VECS[i]);
      run_field(int'(VECS[i].nl), -1, TAGS[i], act);
      chk(act == int'(VECS[i].exp_act), {TAGS[i], " active lines"},
          32'(act), 32'(VECS[i].exp_act));
    end

    // R8: change toggles after the load; field keeps the old window
    sg_line = 12'd1; cfg_pol = 1'b0; cfg_rise = 12'd2; cfg_fall = 12'd5;
    cfg_count = 8'd5; cfg_start_off = '0; cfg_hp = '1;
    alt_rise = 12'd8; alt_fall = 12'd12;
    run_field(9, 3, "R8 mid-field write", act);
    chk(act == 5, "R8 active lines", 32'(act), 32'd5);
    // Next field picks up the new window at its load
    run_field(9, -1, "R8 next field", act);
    chk(act == 5, "R8 next field active lines", 32'(act), 32'd5);

    // R9: count runs past the field end; next field line 0 must be idle
    sg_line = 12'd0; cfg_count = 8'd10; cfg_rise = 12'd0; cfg_fall = 12'd16;
    run_field(4, -1, "R9 short field", act);
    chk(act == 3, "R9 short field active lines", 32'(act), 32'd3);
    run_field(1, -1, "R9 new field line 0", act);
    chk(act == 0, "R9 new field idle", 32'(act), 32'd0);

    // R1/R6: with active-low polarity loaded, reset still forces 0
    cfg_pol = 1'b1; sg_line = 12'd0; cfg_count = 8'd0;
    run_field(3, -1, "R6 idle high", act);
    chk(shutter == 1'b1, "R6 inactive high", 32'(shutter), 32'd1);
    rst_n = 1'b0;
    cyc();
    chk(shutter == 1'b0, "R1 reset over polarity", 32'(shutter), 32'd0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements) act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule